// File: doc/BRIEF.md
# Up/Down Timer Counter

This block is a timer/counter with a small write/read register port. Its counting width is chosen from 8, 16 or 32 bits. In 8-bit mode the counter wraps at a programmable period value. In the wider modes it wraps at the all-ones value of that width. The counter runs upward or downward. It either keeps running or halts after its first wrap. It is started and stopped by commands, and software may overwrite the count at any moment.

Every wrap does three things. It raises a sticky overflow flag, which software clears by writing a one to it. It can emit a one-cycle event pulse. It toggles a single waveform output. A stop command freezes the count, forces the waveform low and reports the halt in a status register. A start command resumes counting from wherever the count stands.

Register map. Writes occur on `wr_en_i`; reads are combinational on `rd_addr_i`:

| Address | Write | Read |
|---|---|---|
| 0 (configuration) | bits [1:0] width code, bit 2 one-shot, bit 3 event enable | same fields |
| 1 (set image) | bit 0 selects down-counting; bits [2:1] are a command (1 = start, 2 = stop, other values do nothing) | direction in bit 0 |
| 2 (clear image) | bit 0 selects up-counting | direction in bit 0 |
| 3 (flag) | writing 1 to bit 0 clears the overflow flag | overflow flag in bit 0 |
| 4 (status) | no effect | bit 0 halted, bit 1 direction (1 = down) |
| 5 (count) | new count value | count, masked to the width |
| 6 (period) | 8-bit period | 8-bit period |

Width codes: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = treated as 16-bit.

Top module: `tc_timer`

## Requirements
- R1: After reset the count reads 0. The configuration reads 1 (16-bit, continuous, event disabled). Status reads 1 (halted, up). The flag, irq_o, ovf_evt_o and wave_o are all 0.
- R2: Counting up in 16-bit mode, the count wraps from 0xFFFF to 0 on the next clock. In 32-bit mode it wraps from 0xFFFFFFFF to 0.
- R3: In 8-bit mode the top value is the period register: counting up from the period value gives 0 on the next clock.
- R4: Counting down, a count of 0 becomes the top value on the next clock. In 8-bit mode that is the period.
- R5: Writing bit 0 = 1 to address 1 selects down-counting. Writing bit 0 = 1 to address 2 selects up-counting. Writing bit 0 = 0 to either address leaves the direction as it was (status bit 1).
- R6: Every wrap sets the overflow flag (flag bit 0 and irq_o) one clock later. Writing 1 to flag bit 0 clears it. When a wrap and a clear happen in the same clock, the flag stays set.
- R7: When event enable (configuration bit 3) is set, ovf_evt_o is high for exactly the one cycle after a wrap. When event enable is clear, ovf_evt_o stays low.
- R8: In one-shot mode (configuration bit 2) the counter halts after its first wrap. Status bit 0 becomes 1, wave_o goes low, and the count stays fixed.
- R9: A stop command (address 1, bits [2:1] = 2) freezes the count in that same clock. It drives wave_o low and sets status bit 0.
- R10: A start command (address 1, bits [2:1] = 1) clears status bit 0. Counting then resumes from the current count value.
- R11: A count write takes effect on the next clock, whether the counter is halted or running, and it takes priority over counting. The count reads back masked to the current width.
- R12: While the counter is running, wave_o toggles on each wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Overflow flag |
| ovf_evt_o | output | 1 | One-cycle overflow event |
| wave_o | output | 1 | Waveform output, toggles per wrap |

## Verification
A wrong top value or a wrong wrap decision is visible on the count readout within one clock of the count reaching its limit. In the same cycle, irq_o and wave_o would be wrong too. A halt state that does not match the commands shows at once in status bit 0, and within one clock the count readout either moves when it should be frozen or stays still when it should move. Priority faults show in the clock right after the conflict: a clear that beats a set, or a count increment that beats a software write, each leave the wrong value on the port.

// File: rtl/tc_pkg.sv
// Shared definitions for the timer counter: counter width, register addresses,
// command codes and the width-mode mask helper.
// Assumes TC_W is at least 32 so that every mode fits in the counter register.
package tc_pkg;

    localparam int TC_W     = 32;
    localparam int TC_AW    = 3;
    localparam int TC_PER_W = 8;

    localparam int ADDR_CFG  = 0;
    localparam int ADDR_DSET = 1;
    localparam int ADDR_DCLR = 2;
    localparam int ADDR_FLAG = 3;
    localparam int ADDR_STAT = 4;
    localparam int ADDR_CNT  = 5;
    localparam int ADDR_PER  = 6;

    localparam logic [1:0] CMD_START = 2'd1;
    localparam logic [1:0] CMD_STOP  = 2'd2;

    typedef enum logic [1:0] {
        MODE_8  = 2'd0,
        MODE_16 = 2'd1,
        MODE_32 = 2'd2,
        MODE_RSV = 2'd3
    } tc_mode_e;

    // Mask of the active count bits for a given width mode (reserved code acts as 16-bit).
    function automatic logic [TC_W-1:0] width_mask(input tc_mode_e m);
        logic [TC_W-1:0] r;
        case (m)
            MODE_8:  r = {{(TC_W-8){1'b0}}, 8'hFF};
            MODE_32: r = {TC_W{1'b1}};
            default: r = {{(TC_W-16){1'b0}}, 16'hFFFF};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tc_regs.sv
// Register decode for the timer counter. Holds the configuration, the
// direction bit and the 8-bit period. Turns writes into single-cycle strobes
// for the commands, the count load and the flag clear.
// Assumes at most one register write per clock (a single write port).
module tc_regs
    import tc_pkg::*;
#(
    parameter int W     = TC_W,
    parameter int AW    = TC_AW,
    parameter int PER_W = TC_PER_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [W-1:0]     wr_data_i,
    output tc_mode_e         mode_o,
    output logic             oneshot_o,
    output logic             evt_en_o,
    output logic             dir_o,
    output logic [PER_W-1:0] period_o,
    output logic             cmd_start_o,
    output logic             cmd_stop_o,
    output logic             cnt_wr_o,
    output logic [W-1:0]     cnt_wdata_o,
    output logic             flag_clr_o
);

    logic hit_cfg, hit_dset, hit_dclr, hit_flag, hit_cnt, hit_per;

    // Address decode of the write port.
    always_comb begin
        hit_cfg  = wr_en_i && (wr_addr_i == AW'(ADDR_CFG));
        hit_dset = wr_en_i && (wr_addr_i == AW'(ADDR_DSET));
        hit_dclr = wr_en_i && (wr_addr_i == AW'(ADDR_DCLR));
        hit_flag = wr_en_i && (wr_addr_i == AW'(ADDR_FLAG));
        hit_cnt  = wr_en_i && (wr_addr_i == AW'(ADDR_CNT));
        hit_per  = wr_en_i && (wr_addr_i == AW'(ADDR_PER));
    end

    // Single-cycle strobes handed to the counter core and flag logic.
    always_comb begin
        cmd_start_o = hit_dset && (wr_data_i[2:1] == CMD_START);
        cmd_stop_o  = hit_dset && (wr_data_i[2:1] == CMD_STOP);
        cnt_wr_o    = hit_cnt;
        cnt_wdata_o = wr_data_i;
        flag_clr_o  = hit_flag && wr_data_i[0];
    end

    // Configuration fields: width mode, one-shot, event enable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_o    <= MODE_16;
            oneshot_o <= 1'b0;
            evt_en_o  <= 1'b0;
        end else if (hit_cfg) begin
            mode_o    <= tc_mode_e'(wr_data_i[1:0]);
            oneshot_o <= wr_data_i[2];
            evt_en_o  <= wr_data_i[3];
        end
    end

    // Direction bit: only ones written to the set or clear image change it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dir_o <= 1'b0;
        end else if (hit_dset && wr_data_i[0]) begin
            dir_o <= 1'b1;
        end else if (hit_dclr && wr_data_i[0]) begin
            dir_o <= 1'b0;
        end
    end

    // Period register used as the top value in 8-bit mode.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            period_o <= '0;
        end else if (hit_per) begin
            period_o <= wr_data_i[PER_W-1:0];
        end
    end

endmodule

// File: rtl/tc_core.sv
// Counter core. Selects the top value for the mode, steps the count up or
// down, detects wraps and tracks the halted state. The priorities, highest
// first: a count write, then a stop, then normal counting.
// Assumes the commands and the count write are mutually exclusive strobes.
module tc_core
    import tc_pkg::*;
#(
    parameter int W     = TC_W,
    parameter int PER_W = TC_PER_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  tc_mode_e         mode_i,
    input  logic             dir_i,
    input  logic             oneshot_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             cmd_start_i,
    input  logic             cmd_stop_i,
    input  logic             cnt_wr_i,
    input  logic [W-1:0]     cnt_wdata_i,
    output logic [W-1:0]     count_o,
    output logic [W-1:0]     mask_o,
    output logic             halted_o,
    output logic             wrap_o
);

    logic [W-1:0] top;
    logic [W-1:0] cur;
    logic         running;
    logic         advance;

    // Active mask, top value and the current in-width count.
    always_comb begin
        mask_o = width_mask(mode_i);
        top    = (mode_i == MODE_8) ? W'(period_i) : mask_o;
        cur    = count_o & mask_o;
    end

    // A step happens when running and nothing of higher priority intervenes.
    always_comb begin
        running = !halted_o;
        advance = running && !cmd_stop_i && !cnt_wr_i;
        wrap_o  = advance && (dir_i ? (cur == '0) : (cur == top));
    end

    // Count register: load, hold, wrap or step.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_o <= '0;
        end else if (cnt_wr_i) begin
            count_o <= cnt_wdata_i & mask_o;
        end else if (advance) begin
            if (wrap_o) begin
                count_o <= dir_i ? top : '0;
            end else if (dir_i) begin
                count_o <= (cur - 1'b1) & mask_o;
            end else begin
                count_o <= (cur + 1'b1) & mask_o;
            end
        end
    end

    // Halted state: set by stop or a one-shot wrap, cleared by start.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            halted_o <= 1'b1;
        end else if (cmd_stop_i) begin
            halted_o <= 1'b1;
        end else if (cmd_start_i) begin
            halted_o <= 1'b0;
        end else if (wrap_o && oneshot_i) begin
            halted_o <= 1'b1;
        end
    end

endmodule

// File: rtl/tc_flags.sv
// Wrap-driven outputs: the sticky overflow flag (set beats clear), the
// one-cycle event pulse and the toggling waveform, which is forced low
// whenever the counter halts.
// Assumes wrap_i is a single-cycle indication from the counter core.
module tc_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wrap_i,
    input  logic flag_clr_i,
    input  logic evt_en_i,
    input  logic oneshot_i,
    input  logic cmd_stop_i,
    output logic flag_o,
    output logic evt_o,
    output logic wave_o
);

    logic wave_kill;

    // The waveform drops on a stop or on the wrap that ends a one-shot run.
    always_comb wave_kill = cmd_stop_i || (wrap_i && oneshot_i);

    // Overflow flag with write-one-to-clear; a wrap in the same clock wins.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_o <= 1'b0;
        end else if (wrap_i) begin
            flag_o <= 1'b1;
        end else if (flag_clr_i) begin
            flag_o <= 1'b0;
        end
    end

    // One-cycle event pulse after each wrap when enabled.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            evt_o <= 1'b0;
        end else begin
            evt_o <= wrap_i && evt_en_i;
        end
    end

    // Waveform output toggles per wrap, cleared on halt.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wave_o <= 1'b0;
        end else if (wave_kill) begin
            wave_o <= 1'b0;
        end else if (wrap_i) begin
            wave_o <= !wave_o;
        end
    end

endmodule

// File: rtl/tc_timer.sv
// Top of the timer counter. Connects the register decode, the counter core
// and the flag logic, and drives the combinational read mux.
// Assumes a single-cycle write port and a purely combinational read port.
module tc_timer
    import tc_pkg::*;
#(
    parameter int W     = TC_W,
    parameter int AW    = TC_AW,
    parameter int PER_W = TC_PER_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o,
    output logic          irq_o,
    output logic          ovf_evt_o,
    output logic          wave_o
);

    tc_mode_e         mode;
    logic             oneshot, evt_en, dir;
    logic [PER_W-1:0] period;
    logic             cmd_start, cmd_stop, cnt_wr, flag_clr;
    logic [W-1:0]     cnt_wdata;
    logic [W-1:0]     count, mask;
    logic             halted, wrap;

    tc_regs #(.W(W), .AW(AW), .PER_W(PER_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .mode_o      (mode),
        .oneshot_o   (oneshot),
        .evt_en_o    (evt_en),
        .dir_o       (dir),
        .period_o    (period),
        .cmd_start_o (cmd_start),
        .cmd_stop_o  (cmd_stop),
        .cnt_wr_o    (cnt_wr),
        .cnt_wdata_o (cnt_wdata),
        .flag_clr_o  (flag_clr)
    );

    tc_core #(.W(W), .PER_W(PER_W)) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_i      (mode),
        .dir_i       (dir),
        .oneshot_i   (oneshot),
        .period_i    (period),
        .cmd_start_i (cmd_start),
        .cmd_stop_i  (cmd_stop),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (cnt_wdata),
        .count_o     (count),
        .mask_o      (mask),
        .halted_o    (halted),
        .wrap_o      (wrap)
    );

    tc_flags u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wrap_i     (wrap),
        .flag_clr_i (flag_clr),
        .evt_en_i   (evt_en),
        .oneshot_i  (oneshot),
        .cmd_stop_i (cmd_stop),
        .flag_o     (irq_o),
        .evt_o      (ovf_evt_o),
        .wave_o     (wave_o)
    );

    // Read mux over the register images.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            AW'(ADDR_CFG):  rd_data_o = W'({evt_en, oneshot, mode});
            AW'(ADDR_DSET),
            AW'(ADDR_DCLR): rd_data_o = W'(dir);
            AW'(ADDR_FLAG): rd_data_o = W'(irq_o);
            AW'(ADDR_STAT): rd_data_o = W'({dir, halted});
            AW'(ADDR_CNT):  rd_data_o = count & mask;
            AW'(ADDR_PER):  rd_data_o = W'(period);
            default:        rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/tc_timer_chk.sv
// Property checker for the timer counter, bound into every tc_timer instance.
// Observes the wrap, command and output signals that separate submodules drive.
module tc_timer_chk
    import tc_pkg::*;
#(
    parameter int W = TC_W
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         wrap,
    input logic         cmd_start,
    input logic         cmd_stop,
    input logic         cnt_wr,
    input logic [W-1:0] cnt_wdata,
    input logic [W-1:0] count,
    input logic         halted,
    input logic         irq_o,
    input logic         ovf_evt_o,
    input logic         wave_o
);

    // R6: a wrap leaves the overflow flag set in the next cycle.
    a_r6_flag_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> irq_o);

    // R7: an event pulse never appears without the flag it reports.
    a_r7_evt_implies_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_evt_o |-> irq_o);

    // R9: while halted the waveform stays low.
    a_r9_halt_wave_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halted |-> !wave_o);

    // R8: a halted counter with no load or start keeps its count.
    a_r8_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halted && !cnt_wr && !cmd_start) |=> $stable(count));

    // R10: a start command leaves the counter running.
    a_r10_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_start && !cmd_stop) |=> !halted);

    // R11: a count load wins over counting; the low byte is always in width.
    a_r11_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr |=> (count[7:0] == $past(cnt_wdata[7:0])));

endmodule

bind tc_timer tc_timer_chk #(.W(W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap      (wrap),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .count     (count),
    .halted    (halted),
    .irq_o     (irq_o),
    .ovf_evt_o (ovf_evt_o),
    .wave_o    (wave_o)
);

// File: tb/tc_timer_tb.sv
`timescale 1ns/1ps
module tc_timer_tb;

    localparam int W  = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          irq, evt, wave;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    tc_timer u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .ovf_evt_o (evt),
        .wave_o    (wave)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Called just after a negedge; the write lands on the following posedge.
    task automatic wr(input int addr, input logic [W-1:0] data);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [W-1:0] data);
        rd_addr = AW'(addr);
        #0.5;
        data = rd_data;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic prep(input logic [W-1:0] cfg, input logic [W-1:0] cnt);
        wr(1, 32'h4);
        wr(0, cfg);
        wr(5, cnt);
        wr(3, 32'h1);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd(5, v); check("R1 count", v, 0);
        rd(0, v); check("R1 cfg", v, 1);
        rd(4, v); check("R1 status", v, 1);
        rd(3, v); check("R1 flag", v, 0);
        check("R1 outputs", {irq, evt, wave}, 0);
    endtask

    task automatic t_up16();
        logic [W-1:0] v;
        prep(32'h1, 32'hFFFE);
        wr(1, 32'h2);
        rd(5, v); check("R10 resume value", v, 32'hFFFE);
        step(); rd(5, v); check("R2 16b top", v, 32'hFFFF);
        check("R6 no flag before wrap", irq, 0);
        step(); rd(5, v); check("R2 16b wrap", v, 0);
        check("R6 flag on wrap", irq, 1);
        check("R12 wave toggled", wave, 1);
        check("R7 no event when disabled", evt, 0);
    endtask

    task automatic t_up32();
        logic [W-1:0] v;
        prep(32'h2, 32'hFFFF_FFFF);
        wr(1, 32'h2);
        rd(5, v); check("R2 32b top", v, 32'hFFFF_FFFF);
        step(); rd(5, v); check("R2 32b wrap", v, 0);
        check("R6 flag 32b", irq, 1);
    endtask

    task automatic t_per8();
        logic [W-1:0] v;
        prep(32'h8, 32'h4);
        wr(6, 32'h5);
        wr(1, 32'h2);
        step(); rd(5, v); check("R3 at period", v, 5);
        check("R7 no event yet", evt, 0);
        step(); rd(5, v); check("R3 8b wrap", v, 0);
        check("R7 event pulse", evt, 1);
        step(); rd(5, v); check("R3 after wrap", v, 1);
        check("R7 event one cycle", evt, 0);
        wr(1, 32'h4);
        wr(3, 32'h1);
        rd(3, v); check("R6 write-one clear", v, 0);
    endtask

    task automatic t_down();
        logic [W-1:0] v;
        prep(32'h0, 32'h1);
        wr(6, 32'h5);
        wr(1, 32'h1);
        wr(1, 32'h2);
        step(); rd(5, v); check("R4 reach zero", v, 0);
        check("R6 no flag at zero yet", irq, 0);
        step(); rd(5, v); check("R4 reload period", v, 5);
        check("R6 flag on underflow", irq, 1);
        wr(1, 32'h4);
        wr(2, 32'h1);
    endtask

    task automatic t_dir();
        logic [W-1:0] v;
        wr(1, 32'h0); rd(4, v); check("R5 set zero no effect", v[1], 0);
        wr(1, 32'h1); rd(4, v); check("R5 set selects down", v[1], 1);
        wr(2, 32'h0); rd(4, v); check("R5 clear zero no effect", v[1], 1);
        wr(2, 32'h1); rd(4, v); check("R5 clear selects up", v[1], 0);
    endtask

    task automatic t_flag_prio();
        logic [W-1:0] v;
        prep(32'h1, 32'hFFFE);
        wr(1, 32'h2);
        step();
        wr(3, 32'h1);
        rd(3, v); check("R6 set beats clear", v, 1);
        wr(3, 32'h1);
        rd(3, v); check("R6 clear alone", v, 0);
        wr(1, 32'h4);
    endtask

    task automatic t_oneshot();
        logic [W-1:0] v;
        prep(32'h5, 32'hFFFF);
        wr(1, 32'h2);
        step(); rd(5, v); check("R8 wrapped", v, 0);
        rd(4, v); check("R8 halted", v[0], 1);
        check("R8 wave low", wave, 0);
        check("R6 oneshot flag", irq, 1);
        step(); step(); rd(5, v); check("R8 count held", v, 0);
    endtask

    task automatic t_stop_start();
        logic [W-1:0] v;
        prep(32'h1, 32'hFFFF);
        wr(1, 32'h2);
        step(); check("R12 wave high after wrap", wave, 1);
        step(); step(); rd(5, v); check("R12 running count", v, 2);
        wr(1, 32'h4);
        rd(5, v); check("R9 stop freezes", v, 2);
        check("R9 wave cleared", wave, 0);
        rd(4, v); check("R9 stop status", v[0], 1);
        step(); step(); rd(5, v); check("R9 still frozen", v, 2);
        wr(1, 32'h2);
        rd(4, v); check("R10 status cleared", v[0], 0);
        step(); rd(5, v); check("R10 resumes from count", v, 3);
        wr(1, 32'h4);
    endtask

    task automatic t_cnt_wr();
        logic [W-1:0] v;
        prep(32'h0, 32'h1234);
        rd(5, v); check("R11 8b masked", v, 32'h34);
        wr(0, 32'h1);
        rd(5, v); check("R11 16b readback", v, 32'h34);
        wr(1, 32'h2);
        step();
        wr(5, 32'h100);
        rd(5, v); check("R11 load beats step", v, 32'h100);
        step(); rd(5, v); check("R11 counts on after load", v, 32'h101);
        wr(1, 32'h4);
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up16();
        t_up32();
        t_per8();
        t_down();
        t_dir();
        t_flag_prio();
        t_oneshot();
        t_stop_start();
        t_cnt_wr();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule